// File: doc/BRIEF.md
# Register Write-Hazard Scoreboard

This block records, one flag per architectural register, whether an instruction now in flight may still write that register. When an instruction is handed to an execution unit, the issue side names the unit, the destination register, and whether decode says a write is possible. If a write is possible, the destination's flag is raised. Each unit keeps its own copy of the destination it was given, so several instructions can be outstanding at once on different units.

When a unit's output handshake completes, the flag the unit was holding is lowered. The handshake alone decides this. A unit that decides at the end not to write still releases its register.

Several query ports each take a mask of source registers. In the same cycle, each port reports whether any register in its mask still has a pending write. Operand reads are held back while the report is high. Storage of register values, forwarding and renaming belong to other blocks.

Top module: `wr_hazard_board`

## Requirements
- R1: While reset is asserted and after it is released, every pending flag is 0 and every query port reports no hazard.
- R2: An issue with `iss_valid=1` and `iss_may_write=1` raises the flag of register `iss_dest` on `pend_o` at the next clock edge.
- R3: An issue with `iss_may_write=0` raises no flag.
- R4: A pulse on `fin_valid[u]` lowers, at the next clock edge, the flag of the register unit u was issued with. No write indication from the unit is taken into account.
- R5: A `fin_valid[u]` pulse for a unit that holds no possible write leaves every flag unchanged.
- R6: `qry_block[q]` is 1 in the same cycle that any register selected in mask slice q of `qry_src` has its flag set. Bit i of slice q is `qry_src[q*NUM_REGS+i]`.
- R7: If an issue raises a register's flag in the same cycle that a completion lowers the same register's flag, the flag ends up set.
- R8: Each unit clears only the register it latched at its own issue, so outstanding writes on other units stay pending. A unit that completes and is re-issued in the same cycle clears its old register and arms its new one.
- R9: A query port whose mask selects no pending register reports 0, independently of the other query ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue of one instruction this cycle |
| iss_unit | input | UW | Index of the unit receiving the instruction |
| iss_dest | input | RW | Destination register number |
| iss_may_write | input | 1 | Decode reports a possible write to `iss_dest` |
| fin_valid | input | NUM_UNITS | Per-unit output handshake completion pulse |
| qry_src | input | NUM_QRY*NUM_REGS | Source-register masks, one slice per query port |
| qry_block | output | NUM_QRY | Per-port hazard: a selected source has a pending write |
| pend_o | output | NUM_REGS | Current pending-write flags |

## Verification
The hardest situation to reach from the ports is a cycle where a completion clears a register and a new issue sets that same register. It needs two units, and the first must already be armed on that register. The stimulus arms unit 0 on a register, then in one cycle pulses unit 0's completion and issues unit 1 to the same destination, and checks that the flag stays high. A related case completes a unit and re-issues that unit in the same cycle, to show that its old register is released while the new one is armed.

// File: rtl/whb_pkg.sv
package whb_pkg;
  typedef enum logic {
    SLOT_IDLE  = 1'b0,
    SLOT_ARMED = 1'b1
  } slot_state_e;
endpackage

// File: rtl/whb_unit_slot.sv
module whb_unit_slot
  import whb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [RW-1:0]       load_dest,
  input  logic                load_may,
  input  logic                done,
  output logic [NUM_REGS-1:0] clr_vec
);
  slot_state_e st_q, st_d;
  logic [RW-1:0] dest_q, dest_d;
  logic dest_en;

  always_comb begin
    st_d    = st_q;
    dest_d  = dest_q;
    dest_en = 1'b0;
    if (load) begin
      dest_en = 1'b1;
      dest_d  = load_dest;
      st_d    = load_may ? SLOT_ARMED : SLOT_IDLE;
    end else if (done) begin
      st_d = SLOT_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SLOT_IDLE;
      dest_q <= '0;
    end else begin
      st_q <= st_d;
      if (dest_en) dest_q <= dest_d;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign clr_vec[i] = done && (st_q == SLOT_ARMED) && (dest_q == RW'(i));
  end
endmodule

// File: rtl/whb_flag_array.sv
module whb_flag_array #(
  parameter int NUM_REGS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] set_vec,
  input  logic [NUM_REGS-1:0] clr_vec,
  output logic [NUM_REGS-1:0] flags
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
    logic en, d;
    always_comb begin
      en = set_vec[i] | clr_vec[i];
      d  = set_vec[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flags[i] <= 1'b0;
      else if (en) flags[i] <= d;
    end
  end
endmodule

// File: rtl/whb_query.sv
module whb_query #(
  parameter int NUM_REGS = 32
) (
  input  logic [NUM_REGS-1:0] src_mask,
  input  logic [NUM_REGS-1:0] flags,
  output logic                block
);
  always_comb block = |(src_mask & flags);
endmodule

// File: rtl/wr_hazard_board.sv
module wr_hazard_board #(
  parameter int NUM_REGS  = 32,
  parameter int NUM_UNITS = 4,
  parameter int NUM_QRY   = 2,
  localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int UW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        iss_valid,
  input  logic [UW-1:0]               iss_unit,
  input  logic [RW-1:0]               iss_dest,
  input  logic                        iss_may_write,
  input  logic [NUM_UNITS-1:0]        fin_valid,
  input  logic [NUM_QRY*NUM_REGS-1:0] qry_src,
  output logic [NUM_QRY-1:0]          qry_block,
  output logic [NUM_REGS-1:0]         pend_o
);
  logic [NUM_REGS-1:0] set_vec;
  logic [NUM_REGS-1:0] clr_vec;
  logic [NUM_REGS-1:0] unit_clr [NUM_UNITS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_set
    assign set_vec[i] = iss_valid && iss_may_write && (iss_dest == RW'(i));
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic load_u;
    assign load_u = iss_valid && (iss_unit == UW'(u));
    whb_unit_slot #(.NUM_REGS(NUM_REGS)) i_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_u),
      .load_dest (iss_dest),
      .load_may  (iss_may_write),
      .done      (fin_valid[u]),
      .clr_vec   (unit_clr[u])
    );
  end

  always_comb begin
    clr_vec = '0;
    for (int u = 0; u < NUM_UNITS; u++) clr_vec = clr_vec | unit_clr[u];
  end

  whb_flag_array #(.NUM_REGS(NUM_REGS)) i_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (pend_o)
  );

  for (genvar q = 0; q < NUM_QRY; q++) begin : g_qry
    whb_query #(.NUM_REGS(NUM_REGS)) i_q (
      .src_mask (qry_src[q*NUM_REGS +: NUM_REGS]),
      .flags    (pend_o),
      .block    (qry_block[q])
    );
  end
endmodule

// File: rtl/whb_checker.sv
module whb_checker #(
  parameter int NUM_REGS  = 32,
  parameter int NUM_UNITS = 4,
  parameter int NUM_QRY   = 2,
  localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int UW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        iss_valid,
  input logic [UW-1:0]               iss_unit,
  input logic [RW-1:0]               iss_dest,
  input logic                        iss_may_write,
  input logic [NUM_UNITS-1:0]        fin_valid,
  input logic [NUM_QRY*NUM_REGS-1:0] qry_src,
  input logic [NUM_QRY-1:0]          qry_block,
  input logic [NUM_REGS-1:0]         pend_o
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pend_o == '0)); // R1

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_may_write) |=> pend_o[$past(iss_dest)]); // R2

  AST_NO_SET_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid && iss_may_write) |=> ((pend_o & ~$past(pend_o)) == '0)); // R3

  AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(pend_o & ~$past(pend_o)) <= 1)); // R2

  AST_NO_FALL_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_valid == '0) |=> ((~pend_o & $past(pend_o)) == '0)); // R4

  for (genvar q = 0; q < NUM_QRY; q++) begin : g_q
    AST_EMPTY_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_src[q*NUM_REGS +: NUM_REGS] == '0) |-> !qry_block[q]); // R9
  end
endmodule

bind wr_hazard_board whb_checker #(
  .NUM_REGS(NUM_REGS), .NUM_UNITS(NUM_UNITS), .NUM_QRY(NUM_QRY)
) i_whb_checker (.*);

// File: tb/test_wr_hazard_board.sv
module test_wr_hazard_board;
  localparam int NR = 32;
  localparam int NU = 4;
  localparam int NQ = 2;

  logic          clk;
  logic          rst_n;
  logic          iss_valid;
  logic [1:0]    iss_unit;
  logic [4:0]    iss_dest;
  logic          iss_may_write;
  logic [NU-1:0] fin_valid;
  logic [NQ*NR-1:0] qry_src;
  logic [NQ-1:0] qry_block;
  logic [NR-1:0] pend_o;

  int n_checks = 0;
  int n_errors = 0;

  logic [NR-1:0] exp_pend;
  logic [4:0]    exp_dest [NU];
  logic [NU-1:0] exp_arm;

  wr_hazard_board #(.NUM_REGS(NR), .NUM_UNITS(NU), .NUM_QRY(NQ)) i_wr_hazard_board (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_unit(iss_unit),
    .iss_dest(iss_dest), .iss_may_write(iss_may_write), .fin_valid(fin_valid),
    .qry_src(qry_src), .qry_block(qry_block), .pend_o(pend_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_vec(string req, logic [NR-1:0] act, logic [NR-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: pend actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive one cycle from a negedge; model the result after the posedge.
  task automatic step(logic v, int u, int d, logic m, logic [NU-1:0] fin);
    logic [NR-1:0] clr, set;
    iss_valid = v; iss_unit = 2'(u); iss_dest = 5'(d); iss_may_write = m;
    fin_valid = fin;
    @(posedge clk);
    #1;
    clr = '0; set = '0;
    for (int k = 0; k < NU; k++)
      if (fin[k] && exp_arm[k]) clr[exp_dest[k]] = 1'b1;
    for (int k = 0; k < NU; k++) if (fin[k]) exp_arm[k] = 1'b0;
    if (v) begin
      exp_dest[u] = 5'(d);
      exp_arm[u]  = m;
      if (m) set[d] = 1'b1;
    end
    exp_pend = (exp_pend & ~clr) | set;
    iss_valid = 1'b0; fin_valid = '0;
    @(negedge clk);
  endtask

  task automatic query(string req, logic [NR-1:0] m0, logic [NR-1:0] m1);
    qry_src = {m1, m0};
    #1;
    check_bit({req, " port0"}, qry_block[0], |(m0 & exp_pend));
    check_bit({req, " port1"}, qry_block[1], |(m1 & exp_pend));
  endtask

  task automatic t_reset();
    check_vec("R1 flags in reset", pend_o, '0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check_vec("R1 flags after release", pend_o, '0);
    query("R1 no hazard", '1, '1);
  endtask

  task automatic t_issue_basic();
    step(1, 0, 5, 1, '0);
    check_vec("R2 set dest 5", pend_o, exp_pend);
    check_bit("R2 bit 5 high", pend_o[5], 1'b1);
    query("R6 hit on 5", NR'(1) << 5, NR'(1) << 6);
    query("R9 miss on 6", NR'(1) << 6, '0);
  endtask

  task automatic t_no_write();
    step(1, 1, 7, 0, '0);
    check_vec("R3 no write raises nothing", pend_o, exp_pend);
    check_bit("R3 bit 7 low", pend_o[7], 1'b0);
    step(0, 0, 0, 0, 4'b0010);
    check_vec("R5 idle unit done no effect", pend_o, exp_pend);
    check_bit("R5 bit 5 kept", pend_o[5], 1'b1);
  endtask

  task automatic t_multi();
    step(1, 2, 9, 1, '0);
    step(1, 3, 0, 1, '0);
    step(1, 1, 31, 1, '0);
    check_vec("R8 four in flight", pend_o, exp_pend);
    query("R6 multi source", (NR'(1) << 31) | (NR'(1) << 8), NR'(1) << 0);
    step(0, 0, 0, 0, 4'b0100);
    check_vec("R4 unit2 clears only 9", pend_o, exp_pend);
    check_bit("R8 bit 31 kept", pend_o[31], 1'b1);
    check_bit("R4 bit 9 cleared", pend_o[9], 1'b0);
    query("R9 cleared reg not blocking", NR'(1) << 9, NR'(1) << 0);
  endtask

  task automatic t_set_wins();
    step(1, 1, 5, 1, 4'b0011);
    check_bit("R7 set beats clear on 5", pend_o[5], 1'b1);
    check_bit("R4 unit1 old dest 31 cleared", pend_o[31], 1'b0);
    check_vec("R7 whole vector", pend_o, exp_pend);
    step(0, 0, 0, 0, 4'b0010);
    check_bit("R4 unit1 releases 5", pend_o[5], 1'b0);
  endtask

  task automatic t_reissue();
    step(1, 3, 12, 1, 4'b1000);
    check_bit("R8 unit3 old dest 0 cleared", pend_o[0], 1'b0);
    check_bit("R8 unit3 new dest 12 set", pend_o[12], 1'b1);
    check_vec("R8 vector", pend_o, exp_pend);
    step(0, 0, 0, 0, 4'b1000);
    check_vec("R4 all released", pend_o, '0);
    query("R9 empty board", '1, '1);
  endtask

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; iss_unit = '0; iss_dest = '0;
    iss_may_write = 1'b0; fin_valid = '0; qry_src = '0;
    exp_pend = '0; exp_arm = '0;
    for (int k = 0; k < NU; k++) exp_dest[k] = '0;
    @(negedge clk); @(negedge clk);
    t_reset();
    t_issue_basic();
    t_no_write();
    t_multi();
    t_set_wins();
    t_reissue();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule